// File: doc/BRIEF.md
# Data Bus Tenure Arbiter

This block hands out data bus tenures on a split-transaction bus, where the address phase and the data phase are arbitrated separately. Masters never ask for the data bus directly. Whenever a master opens an address tenure that will move data, the arbiter records a pending data tenure for that master. The record holds the master number, a tenure tag and a beat-length flag. Address-only tenures leave no record.

When the data bus is idle, the arbiter chooses among the pending tenures. The lowest-numbered master that has a pending tenure wins, and that master's oldest tenure is offered. The arbiter raises a one-cycle grant toward the winning master. The grant counts only if no address retry names the same tag in that cycle. A counted grant drives the busy output for one or four cycles. A retried grant, or a retried tenure still waiting in the queue, is discarded and never occupies the bus.

Top module: `dta_arbiter`

## Requirements
- R1: After synchronous reset, no grant is raised, `dbb` is low, `dtake` is low, and no tenure is pending.
- R2: A cycle with `ts_start` high and `ts_addr_only` low queues one pending tenure (`ts_mst`, `ts_tag`, `ts_long`). A cycle with `ts_addr_only` high queues nothing, so no grant ever follows from it.
- R3: `dbg` is one-hot, with bit m meaning master m. The grant is raised in the first cycle in which `dbb` is low, at least one tenure is pending, and the previous cycle carried no grant. It stays high for exactly one cycle, and `dbg_tag` carries the granted tag during that cycle.
- R4: Among pending tenures, the lowest master number wins. Within one master, tenures are granted in the order in which their address tenures started.
- R5: `dtake` is high in the grant cycle unless R7 applies. `dbb` then stays high for 1 cycle (`ts_long`=0) or 4 cycles (`ts_long`=1), starting in the cycle after the grant.
- R6: No grant is raised while `dbb` is high or in the cycle right after a grant.
- R7: An `artry_vld` in the grant cycle whose `artry_tag` equals `dbg_tag` makes the grant unqualified. `dtake` stays low, `dbb` stays low, and the tenure is dropped.
- R8: An `artry_vld` in the grant cycle with a tag different from `dbg_tag` does not affect `dtake` or the following busy period.
- R9: An `artry_vld` whose tag matches a pending tenure that is not being granted removes that tenure, so it is never granted.
- R10: At most 4 tenures are pending. A start that arrives while the queue is full, after removals in the same cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_start | input | 1 | Address tenure start strobe |
| ts_addr_only | input | 1 | The starting tenure moves no data |
| ts_mst | input | 2 | Master number of the starting tenure |
| ts_tag | input | 4 | Tag of the starting tenure |
| ts_long | input | 1 | 1: four-beat data tenure, 0: single beat |
| artry_vld | input | 1 | Address retry strobe |
| artry_tag | input | 4 | Tag of the retried address tenure |
| dbg | output | 4 | One-hot data grant pulse per master |
| dbg_tag | output | 4 | Tag of the tenure being granted |
| dtake | output | 1 | Grant is qualified; the master takes the data bus |
| dbb | output | 1 | Data bus busy |

## Verification
The hardest situation to reach is a full queue whose entries come from several masters while the bus is held busy. It is the only way to observe priority, per-master age order and overflow rejection together. The stimulus gets there by opening a four-beat tenure first. It then starts four more tenures, in reverse priority order, during that tenure's busy cycles, and sends a fifth start while the queue is full. A separate sequence drives a retry in the exact grant cycle, once naming the granted tag and once naming a queued neighbour, to separate R7 from R8 and R9.

// File: rtl/dta_pkg.sv
package dta_pkg;
    localparam int N_MST      = 4;
    localparam int MID_W      = $clog2(N_MST);
    localparam int TAG_W      = 4;
    localparam int DEPTH      = 4;
    localparam int IDX_W      = $clog2(DEPTH);
    localparam int LONG_BEATS = 4;
    localparam int CNT_W      = $clog2(LONG_BEATS + 1);

    typedef struct packed {
        logic             vld;
        logic [MID_W-1:0] mst;
        logic [TAG_W-1:0] tag;
        logic             lng;
    } pend_t;

    function automatic logic [CNT_W-1:0] beats_of(input logic lng);
        return lng ? CNT_W'(LONG_BEATS) : CNT_W'(1);
    endfunction
endpackage

// File: rtl/dta_pend_queue.sv
module dta_pend_queue
    import dta_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ins_req,
    input  logic [MID_W-1:0]       ins_mst,
    input  logic [TAG_W-1:0]       ins_tag,
    input  logic                   ins_lng,
    input  logic                   rm_a_vld,
    input  logic [TAG_W-1:0]       rm_a_tag,
    input  logic                   rm_b_vld,
    input  logic [TAG_W-1:0]       rm_b_tag,
    output pend_t [DEPTH-1:0]      ent_o
);
    pend_t [DEPTH-1:0] q_r;
    pend_t [DEPTH-1:0] q_nxt;
    logic  [DEPTH-1:0] keep;

    // per-slot survival after this cycle's removals
    for (genvar i = 0; i < DEPTH; i++) begin : g_keep
        assign keep[i] = q_r[i].vld
                       && !(rm_a_vld && q_r[i].tag == rm_a_tag)
                       && !(rm_b_vld && q_r[i].tag == rm_b_tag);
    end

    // compact survivors toward slot 0 (oldest), then append the new start
    always_comb begin
        int unsigned k;
        q_nxt = '0;
        k = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (keep[i]) begin
                q_nxt[IDX_W'(k)] = q_r[i];
                k++;
            end
        end
        if (ins_req && k < DEPTH) begin
            q_nxt[IDX_W'(k)].vld = 1'b1;
            q_nxt[IDX_W'(k)].mst = ins_mst;
            q_nxt[IDX_W'(k)].tag = ins_tag;
            q_nxt[IDX_W'(k)].lng = ins_lng;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= q_nxt;
    end

    assign ent_o = q_r;

    // R10: occupied slots stay packed toward the head
    for (genvar i = 1; i < DEPTH; i++) begin : g_pack
        assert_packed_R10: assert property (@(posedge clk) disable iff (rst)
            q_r[i].vld |-> q_r[i-1].vld);
    end
endmodule

// File: rtl/dta_prio_pick.sv
module dta_prio_pick
    import dta_pkg::*;
(
    input  pend_t [DEPTH-1:0] ent,
    output logic              any_o,
    output logic [MID_W-1:0]  win_mst,
    output logic [TAG_W-1:0]  head_tag,
    output logic              head_lng
);
    always_comb begin
        logic             found;
        logic [IDX_W-1:0] best;
        found = 1'b0;
        best  = '0;
        // walk from youngest to oldest; <= lets older slots of the best master win
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (ent[i].vld && (!found || ent[i].mst <= ent[best].mst)) begin
                found = 1'b1;
                best  = IDX_W'(i);
            end
        end
        any_o    = found;
        win_mst  = ent[best].mst;
        head_tag = ent[best].tag;
        head_lng = ent[best].lng;
    end
endmodule

// File: rtl/dta_tenure_ctl.sv
module dta_tenure_ctl
    import dta_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              any_pend,
    input  logic [MID_W-1:0]  win_mst,
    input  logic [TAG_W-1:0]  head_tag,
    input  logic              head_lng,
    input  logic              artry_vld,
    input  logic [TAG_W-1:0]  artry_tag,
    output logic [N_MST-1:0]  dbg,
    output logic [TAG_W-1:0]  dbg_tag,
    output logic              dtake,
    output logic              dbb,
    output logic              drop_vld,
    output logic [TAG_W-1:0]  drop_tag
);
    logic [CNT_W-1:0] busy_q;
    logic             gnt_q;
    logic             grant_en;
    logic             retry_hit;

    assign grant_en  = any_pend && (busy_q == '0) && !gnt_q;
    assign retry_hit = artry_vld && (artry_tag == head_tag);
    assign dbg       = grant_en ? (N_MST'(1) << win_mst) : '0;
    assign dbg_tag   = grant_en ? head_tag : '0;
    assign dtake     = grant_en && !retry_hit;
    assign dbb       = (busy_q != '0);
    assign drop_vld  = grant_en;
    assign drop_tag  = head_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            gnt_q  <= 1'b0;
        end else begin
            gnt_q <= grant_en;
            if (dtake)              busy_q <= beats_of(head_lng);
            else if (busy_q != '0)  busy_q <= busy_q - 1'b1;
        end
    end

    assert_gnt_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dbg));
    assert_gnt_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (dbg != '0) |=> (dbg == '0));
    assert_no_gnt_busy_R6: assert property (@(posedge clk) disable iff (rst)
        dbb |-> (dbg == '0));
    assert_take_busy_R5: assert property (@(posedge clk) disable iff (rst)
        dtake |=> dbb);
    assert_short_len_R5: assert property (@(posedge clk) disable iff (rst)
        (dtake && !head_lng) |=> dbb ##1 !dbb);
    assert_retry_block_R7: assert property (@(posedge clk) disable iff (rst)
        ((dbg != '0) && artry_vld && artry_tag == dbg_tag) |=> !dbb);
    assert_other_retry_R8: assert property (@(posedge clk) disable iff (rst)
        ((dbg != '0) && artry_vld && artry_tag != dbg_tag) |-> dtake);
endmodule

// File: rtl/dta_arbiter.sv
module dta_arbiter
    import dta_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ts_start,
    input  logic              ts_addr_only,
    input  logic [MID_W-1:0]  ts_mst,
    input  logic [TAG_W-1:0]  ts_tag,
    input  logic              ts_long,
    input  logic              artry_vld,
    input  logic [TAG_W-1:0]  artry_tag,
    output logic [N_MST-1:0]  dbg,
    output logic [TAG_W-1:0]  dbg_tag,
    output logic              dtake,
    output logic              dbb
);
    pend_t [DEPTH-1:0] ent;
    logic              any_pend;
    logic [MID_W-1:0]  win_mst;
    logic [TAG_W-1:0]  head_tag;
    logic              head_lng;
    logic              drop_vld;
    logic [TAG_W-1:0]  drop_tag;

    dta_pend_queue u_queue (
        .clk      (clk),
        .rst      (rst),
        .ins_req  (ts_start && !ts_addr_only),
        .ins_mst  (ts_mst),
        .ins_tag  (ts_tag),
        .ins_lng  (ts_long),
        .rm_a_vld (artry_vld),
        .rm_a_tag (artry_tag),
        .rm_b_vld (drop_vld),
        .rm_b_tag (drop_tag),
        .ent_o    (ent)
    );

    dta_prio_pick u_pick (
        .ent      (ent),
        .any_o    (any_pend),
        .win_mst  (win_mst),
        .head_tag (head_tag),
        .head_lng (head_lng)
    );

    dta_tenure_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .any_pend  (any_pend),
        .win_mst   (win_mst),
        .head_tag  (head_tag),
        .head_lng  (head_lng),
        .artry_vld (artry_vld),
        .artry_tag (artry_tag),
        .dbg       (dbg),
        .dbg_tag   (dbg_tag),
        .dtake     (dtake),
        .dbb       (dbb),
        .drop_vld  (drop_vld),
        .drop_tag  (drop_tag)
    );

    // R1: the first cycle out of reset carries neither grant nor busy
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (dbg == '0 && !dbb));
endmodule

// File: tb/dta_arbiter_tb.sv
`timescale 1ns/1ps
module dta_arbiter_tb;
    import dta_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ts_start = 1'b0, ts_addr_only = 1'b0, ts_long = 1'b0;
    logic [MID_W-1:0] ts_mst = '0;
    logic [TAG_W-1:0] ts_tag = '0;
    logic             artry_vld = 1'b0;
    logic [TAG_W-1:0] artry_tag = '0;
    logic [N_MST-1:0] dbg;
    logic [TAG_W-1:0] dbg_tag;
    logic             dtake, dbb;

    dta_arbiter u_dut (
        .clk(clk), .rst(rst), .ts_start(ts_start), .ts_addr_only(ts_addr_only),
        .ts_mst(ts_mst), .ts_tag(ts_tag), .ts_long(ts_long),
        .artry_vld(artry_vld), .artry_tag(artry_tag),
        .dbg(dbg), .dbg_tag(dbg_tag), .dtake(dtake), .dbb(dbb)
    );

    always #2 clk = ~clk;

    typedef struct {
        int mst;
        int tag;
        int beats;
        bit take;
        int ready;
    } exp_t;

    exp_t sb[$];
    int   checks = 0, errors = 0, cyc = 0, exp_left = 0;
    bit   prev_g = 1'b0, running = 1'b0, done = 1'b0;

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, expv, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    // monitor: pops expected grants, tracks busy windows
    always @(negedge clk) begin
        if (running) begin
            bit g;
            g = (dbg != '0);
            chk(dbb == (exp_left != 0), "R5 busy window", int'(dbb), int'(exp_left != 0));
            if (g) begin
                chk(!prev_g, "R3 pulse width", 1, 0);
                chk(exp_left == 0, "R6 grant while busy", exp_left, 0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R2/R9/R10 unexpected grant", int'(dbg), 0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk(dbg == (N_MST'(1) << it.mst), "R4 grant master", int'(dbg), 1 << it.mst);
                    chk(dbg_tag == TAG_W'(it.tag), "R4 grant tag", int'(dbg_tag), it.tag);
                    chk(dtake == it.take, "R7/R8 qualified take", int'(dtake), int'(it.take));
                    if (it.take) exp_left = it.beats + 1;
                end
            end else if (sb.size() > 0 && sb[0].ready <= cyc && exp_left == 0 && !prev_g) begin
                chk(1'b0, "R3 grant late", 0, 1 << sb[0].mst);
            end
            if (exp_left > 0) exp_left--;
            prev_g = g;
        end
    end

    task automatic step(input bit ts, input bit ao, input int m, input int tg,
                        input bit lg, input bit av, input int at);
        @(posedge clk); #1;
        ts_start = ts; ts_addr_only = ao; ts_mst = MID_W'(m);
        ts_tag = TAG_W'(tg); ts_long = lg;
        artry_vld = av; artry_tag = TAG_W'(at);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic push(input int m, input int tg, input bit lg, input bit tk);
        exp_t it;
        it.mst = m; it.tag = tg; it.beats = lg ? 4 : 1; it.take = tk; it.ready = cyc + 1;
        sb.push_back(it);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        chk(dbg == '0, "R1 grant after reset", int'(dbg), 0);
        chk(!dbb, "R1 busy after reset", int'(dbb), 0);
        chk(!dtake, "R1 take after reset", int'(dtake), 0);
        running = 1'b1;
        idle(3);

        // R2/R3/R5: single short tenure
        step(1, 0, 2, 1, 0, 0, 0); push(2, 1, 0, 1);
        idle(5);

        // R2: address-only start queues nothing
        step(1, 1, 1, 2, 0, 0, 0);
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 0, 0, 0, 0, 0);
            @(negedge clk);
            chk(dbg == '0, "R2 address-only grant", int'(dbg), 0);
        end

        // R5: four-beat tenure
        step(1, 0, 0, 3, 1, 0, 0); push(0, 3, 1, 1);
        idle(8);

        // R4/R6/R10: fill the queue while a long tenure holds the bus
        step(1, 0, 2, 8, 1, 0, 0); push(2, 8, 1, 1);
        step(1, 0, 3, 4, 0, 0, 0);
        step(1, 0, 1, 5, 0, 0, 0);
        step(1, 0, 1, 6, 0, 0, 0);
        step(1, 0, 0, 7, 0, 0, 0);
        step(1, 0, 0, 9, 0, 0, 0);   // R10: queue full, ignored
        push(0, 7, 0, 1); push(1, 5, 0, 1); push(1, 6, 0, 1); push(3, 4, 0, 1);
        idle(14);

        // R7: retry names the granted tag in the grant cycle
        step(1, 0, 1, 10, 0, 0, 0); push(1, 10, 0, 0);
        step(0, 0, 0, 0, 0, 1, 10);
        idle(6);

        // R8/R9: retry of a queued neighbour in another tenure's grant cycle
        step(1, 0, 2, 11, 1, 0, 0); push(2, 11, 1, 1);
        step(1, 0, 0, 12, 0, 0, 0);
        step(1, 0, 3, 13, 0, 0, 0); push(0, 12, 0, 1);
        idle(3);
        step(0, 0, 0, 0, 0, 1, 13);
        idle(10);

        chk(sb.size() == 0, "R3 missing grants", sb.size(), 0);
        finish_run();
    end
endmodule